// File: doc/BRIEF.md
# Double Data Rate Pad Buffer

This block sits between core logic and a pad and moves two data words per clock cycle in each direction. On the way out, the core presents a pair of words at each rising edge of the output clock. The pad carries the first word while that clock is high and the second word while it is low. On the way in, the pad is sampled on the rising edge and again on the following falling edge of the input clock. The two samples are handed to the core as one pair on the next rising edge.

The output and input paths run on clocks of their own, so a capture clock can be shifted against the launch clock. A mask parameter inverts selected pad bits in both directions. A direction parameter picks a variant. The input-only variant never drives the pad. The output-only variant always drives it and ignores the enable input. The bidirectional variant registers one enable bit per cycle. The registers have no reset, no clock enable and no initial value.

Top module: `ddr_io_buffer`

## Requirements
- R1: With DIR = DIR_OUTPUT, `pad_oe` is 1 at all times, whatever value `out_en` has.
- R2: With DIR = DIR_INPUT, `pad_oe` is 0 and `pad_out` is all zeros at all times, whatever `out_data` and `out_en` carry.
- R3: With DIR = DIR_BIDIR, `pad_oe` takes the value `out_en` had at the latest rising edge of `out_clk` and holds it until the next rising edge.
- R4: While `out_clk` is high, `pad_out` carries element 0 of the `out_data` pair sampled at the latest rising edge of `out_clk`.
- R5: While `out_clk` is low, `pad_out` carries element 1 of that same pair, so the pad changes twice per cycle in the order element 0, then element 1.
- R6: Bit b of `INV_MASK` set to 1 inverts pad bit b: `pad_out` bit = core bit XOR mask bit, and core input bit = `pad_in` bit XOR mask bit. Bits whose mask bit is 0 pass unchanged.
- R7: Element 0 of `in_data` holds `pad_in` sampled at a rising edge of `in_clk`. Element 1 holds `pad_in` sampled at the following falling edge. Both appear together at the next rising edge of `in_clk` and hold for a full cycle.
- R8: `in_clk` and `out_clk` are independent. With the input clock shifted a quarter period behind the output clock, a bidirectional buffer with `out_en` = 1 whose `pad_out` is looped back to `pad_in` returns in `in_data` the same pair that was written, one input cycle later.
- R9: With DIR = DIR_BIDIR and `out_en` = 0, the input path returns whatever value is driven onto `pad_in` from outside, so each element reflects the external value at its own sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| out_clk | input | 1 | Clock of the output path; both of its edges are used |
| in_clk | input | 1 | Clock of the input path; both of its edges are used |
| out_data | input | 2 x WIDTH | Word pair to send: element 0 in the high phase, element 1 in the low phase |
| out_en | input | 1 | Per-cycle drive request; used only by the bidirectional variant |
| pad_out | output | WIDTH | Value toward the pad driver |
| pad_oe | output | 1 | Pad driver enable |
| pad_in | input | WIDTH | Value seen at the pad |
| in_data | output | 2 x WIDTH | Received pair: element 0 from the rising edge, element 1 from the falling edge |

## Verification
The bound checker confirms on every clock edge the fixed enable of each variant (R1, R2) and the one-cycle registration of the bidirectional enable (R3). It also checks on both edges of `out_clk` that the pad shows the correct element of the latest captured pair with the mask applied (R4 to R6), and on each rising edge of `in_clk` that the received pair equals the two previous half-cycle samples (R7). Only the bench scenarios show the behaviour that spans both clock domains. This covers the loopback round trip with a quarter-period clock offset (R8), the switch to an external driver when the enable drops (R9), and the patterns chosen for the corner cases: all ones, all zeros and an alternating enable.

// File: rtl/ddr_io_pkg.sv
package ddr_io_pkg;

    // Transfers per clock cycle on each path
    localparam int XFERS = 2;

    typedef enum logic [1:0] {
        DIR_INPUT  = 2'd0,
        DIR_OUTPUT = 2'd1,
        DIR_BIDIR  = 2'd2
    } dir_e;

    // True when the variant has an output path toward the pad
    function automatic bit drives_pad(dir_e d);
        return (d == DIR_OUTPUT) || (d == DIR_BIDIR);
    endfunction

    // True when the variant has an input path from the pad
    function automatic bit reads_pad(dir_e d);
        return (d == DIR_INPUT) || (d == DIR_BIDIR);
    endfunction

    // True when the variant drives the pad regardless of the enable input
    function automatic bit always_drives(dir_e d);
        return d == DIR_OUTPUT;
    endfunction

endpackage

// File: rtl/ddr_out_path.sv
module ddr_out_path
    import ddr_io_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] INV_MASK    = '0,
    parameter bit               FORCE_DRIVE = 1'b0
) (
    input  logic                        clk,
    input  logic [XFERS-1:0][WIDTH-1:0] data,
    input  logic                        en,
    output logic [WIDTH-1:0]            pad,
    output logic                        pad_en
);

    // Both words are taken on the rising edge so they stay stable all cycle
    logic [WIDTH-1:0] rise_q;
    logic [WIDTH-1:0] late_hold_q;
    // Second word moved onto a falling-edge register for the low phase
    logic [WIDTH-1:0] fall_q;

    always_ff @(posedge clk) begin
        rise_q      <= data[0] ^ INV_MASK;
        late_hold_q <= data[1] ^ INV_MASK;
    end

    always_ff @(negedge clk) begin
        fall_q <= late_hold_q;
    end

    // Clock level picks the half-cycle value
    assign pad = clk ? rise_q : fall_q;

    generate
        if (FORCE_DRIVE) begin : g_forced
            logic unused_en;
            assign unused_en = en;
            assign pad_en    = 1'b1;
        end else begin : g_registered
            logic en_q;
            always_ff @(posedge clk) begin
                en_q <= en;
            end
            assign pad_en = en_q;
        end
    endgenerate

endmodule

// File: rtl/ddr_in_path.sv
module ddr_in_path
    import ddr_io_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] INV_MASK = '0
) (
    input  logic                        clk,
    input  logic [WIDTH-1:0]            pad,
    output logic [XFERS-1:0][WIDTH-1:0] q
);

    logic [WIDTH-1:0] rise_s;
    logic [WIDTH-1:0] fall_s;

    always_ff @(posedge clk) begin
        rise_s <= pad ^ INV_MASK;
    end

    always_ff @(negedge clk) begin
        fall_s <= pad ^ INV_MASK;
    end

    // Realign the pair onto the rising edge
    always_ff @(posedge clk) begin
        q[0] <= rise_s;
        q[1] <= fall_s;
    end

endmodule

// File: rtl/ddr_io_buffer.sv
module ddr_io_buffer
    import ddr_io_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter dir_e             DIR      = DIR_BIDIR,
    parameter logic [WIDTH-1:0] INV_MASK = '0
) (
    input  logic                        out_clk,
    input  logic                        in_clk,
    input  logic [XFERS-1:0][WIDTH-1:0] out_data,
    input  logic                        out_en,
    output logic [WIDTH-1:0]            pad_out,
    output logic                        pad_oe,
    input  logic [WIDTH-1:0]            pad_in,
    output logic [XFERS-1:0][WIDTH-1:0] in_data
);

    localparam bit HAS_OUT = drives_pad(DIR);
    localparam bit HAS_IN  = reads_pad(DIR);
    localparam bit FORCED  = always_drives(DIR);

    // Ports left idle by some variants
    logic unused_ports;
    assign unused_ports = ^{out_clk, in_clk, out_data, out_en, pad_in};

    generate
        if (HAS_OUT) begin : g_out
            ddr_out_path #(
                .WIDTH      (WIDTH),
                .INV_MASK   (INV_MASK),
                .FORCE_DRIVE(FORCED)
            ) u_out (
                .clk   (out_clk),
                .data  (out_data),
                .en    (out_en),
                .pad   (pad_out),
                .pad_en(pad_oe)
            );
        end else begin : g_no_out
            assign pad_out = '0;
            assign pad_oe  = 1'b0;
        end

        if (HAS_IN) begin : g_in
            ddr_in_path #(
                .WIDTH   (WIDTH),
                .INV_MASK(INV_MASK)
            ) u_in (
                .clk(in_clk),
                .pad(pad_in),
                .q  (in_data)
            );
        end else begin : g_no_in
            assign in_data = '0;
        end
    endgenerate

endmodule

// File: rtl/ddr_io_buffer_chk.sv
module ddr_io_buffer_chk
    import ddr_io_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter dir_e             DIR      = DIR_BIDIR,
    parameter logic [WIDTH-1:0] INV_MASK = '0
) (
    input logic                        out_clk,
    input logic                        in_clk,
    input logic [XFERS-1:0][WIDTH-1:0] out_data,
    input logic                        out_en,
    input logic [WIDTH-1:0]            pad_out,
    input logic                        pad_oe,
    input logic [WIDTH-1:0]            pad_in,
    input logic [XFERS-1:0][WIDTH-1:0] in_data
);

    logic unused_chk;
    assign unused_chk = ^{out_clk, in_clk, out_data, out_en, pad_out, pad_oe, pad_in, in_data};

    // Edge counters that hold checks off until the registers are filled
    logic [1:0] warm_o;
    logic [1:0] warm_i;
    initial warm_o = 2'd0;
    initial warm_i = 2'd0;

    always @(posedge out_clk) if (warm_o != 2'd3) warm_o <= warm_o + 2'd1;
    always @(posedge in_clk)  if (warm_i != 2'd3) warm_i <= warm_i + 2'd1;

    generate
        if (DIR == DIR_OUTPUT) begin : g_chk_forced
            // R1
            forced_drive_chk: assert property (@(posedge out_clk) pad_oe == 1'b1);
        end

        if (DIR == DIR_INPUT) begin : g_chk_quiet
            // R2
            quiet_pad_chk: assert property (@(posedge in_clk)
                (pad_oe == 1'b0) && (pad_out == '0));
        end

        if (DIR == DIR_BIDIR) begin : g_chk_enable
            // R3
            enable_reg_chk: assert property (@(posedge out_clk) disable iff (warm_o < 2'd2)
                pad_oe == $past(out_en));
        end

        if (drives_pad(DIR)) begin : g_chk_out
            logic [WIDTH-1:0] want_hi;
            logic [WIDTH-1:0] want_lo;
            always @(posedge out_clk) begin
                want_hi <= out_data[0] ^ INV_MASK;
                want_lo <= out_data[1] ^ INV_MASK;
            end
            // R4
            high_phase_chk: assert property (@(negedge out_clk) disable iff (warm_o < 2'd1)
                pad_out == want_hi);
            // R5
            low_phase_chk: assert property (@(posedge out_clk) disable iff (warm_o < 2'd2)
                pad_out == want_lo);
        end

        if (reads_pad(DIR)) begin : g_chk_in
            logic [WIDTH-1:0] seen_r;
            logic [WIDTH-1:0] seen_f;
            always @(posedge in_clk) seen_r <= pad_in ^ INV_MASK;
            always @(negedge in_clk) seen_f <= pad_in ^ INV_MASK;
            // R7
            capture_pair_chk: assert property (@(posedge in_clk) disable iff (warm_i < 2'd3)
                in_data == $past({seen_f, seen_r}));
        end
    endgenerate

endmodule

bind ddr_io_buffer ddr_io_buffer_chk #(
    .WIDTH   (WIDTH),
    .DIR     (DIR),
    .INV_MASK(INV_MASK)
) u_chk (.*);

// File: tb/ddr_io_buffer_test.sv
module ddr_io_buffer_test;
    import ddr_io_pkg::*;

    localparam int PERIOD  = 20;
    localparam int NCYC    = 60;
    localparam logic [7:0] MASK_B = 8'hA5;
    localparam logic [3:0] MASK_O = 4'h3;
    localparam logic [3:0] MASK_I = 4'h9;

    logic oclk;
    logic iclk;

    int checks;
    int fails;
    bit done;

    // Bidirectional buffer, looped back when it drives
    logic [1:0][7:0] drv_data;
    logic            drv_oe;
    logic [7:0]      ext_val;
    logic [7:0]      b_pad_out;
    logic            b_pad_oe;
    logic [7:0]      b_pad_in;
    logic [1:0][7:0] b_in_data;

    assign b_pad_in = b_pad_oe ? b_pad_out : ext_val;

    ddr_io_buffer #(.WIDTH(8), .DIR(DIR_BIDIR), .INV_MASK(MASK_B)) uut (
        .out_clk (oclk),
        .in_clk  (iclk),
        .out_data(drv_data),
        .out_en  (drv_oe),
        .pad_out (b_pad_out),
        .pad_oe  (b_pad_oe),
        .pad_in  (b_pad_in),
        .in_data (b_in_data)
    );

    // Output-only buffer, enable held low to show it is ignored
    logic [1:0][3:0] o_data;
    logic [3:0]      o_pad_out;
    logic            o_pad_oe;
    logic [1:0][3:0] o_in_data;
    assign o_data = {drv_data[1][3:0], drv_data[0][3:0]};

    ddr_io_buffer #(.WIDTH(4), .DIR(DIR_OUTPUT), .INV_MASK(MASK_O)) u_out (
        .out_clk (oclk),
        .in_clk  (iclk),
        .out_data(o_data),
        .out_en  (1'b0),
        .pad_out (o_pad_out),
        .pad_oe  (o_pad_oe),
        .pad_in  (4'h0),
        .in_data (o_in_data)
    );

    // Input-only buffer, enable held high to show it is ignored
    logic [3:0]      xin;
    logic [3:0]      i_pad_out;
    logic            i_pad_oe;
    logic [1:0][3:0] i_in_data;

    ddr_io_buffer #(.WIDTH(4), .DIR(DIR_INPUT), .INV_MASK(MASK_I)) u_in (
        .out_clk (oclk),
        .in_clk  (iclk),
        .out_data(8'hFF),
        .out_en  (1'b1),
        .pad_out (i_pad_out),
        .pad_oe  (i_pad_oe),
        .pad_in  (xin),
        .in_data (i_in_data)
    );

    initial begin
        oclk = 1'b0;
        forever #(PERIOD/2) oclk = ~oclk;
    end

    // Input clock trails the output clock by a quarter period
    initial begin
        iclk = 1'b0;
        #(PERIOD/4);
        forever #(PERIOD/2) iclk = ~iclk;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] word0(input int i);
        if (i == 5)  return 8'hFF;
        if (i == 6)  return 8'h00;
        return 8'(i * 29) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] word1(input int i);
        logic [7:0] w;
        if (i == 5)  return 8'h00;
        if (i == 6)  return 8'hFF;
        w = word0(i);
        return {w[3:0], w[7:4]} ^ 8'(i);
    endfunction

    function automatic logic en_of(input int i);
        if (i < 20) return 1'b1;
        if (i < 40) return 1'b0;
        return i[0];
    endfunction

    initial begin
        logic [15:0] exp_b[$];
        logic [7:0]  exp_i[$];
        logic [1:0][7:0] cur_d;
        logic        cur_oe;
        logic [7:0]  p0;
        logic [7:0]  p1;
        logic [3:0]  a0;
        logic [3:0]  a1;
        logic [15:0] want;
        logic [7:0]  want_i;
        checks = 0;
        fails  = 0;
        done   = 1'b0;
        ext_val = 8'h00;
        xin     = 4'h0;
        drv_data = {word1(0), word0(0)};
        drv_oe   = en_of(0);

        for (int i = 0; i < NCYC; i++) begin
            @(posedge oclk);
            #3;
            cur_d  = drv_data;
            cur_oe = drv_oe;

            // R3: enable registered at this rising edge
            check("R3", {15'd0, b_pad_oe}, {15'd0, cur_oe});
            // R1 and R2: fixed enables of the one-way variants
            check("R1", {15'd0, o_pad_oe}, 16'd1);
            check("R2", {11'd0, i_pad_oe, i_pad_out}, 16'd0);
            // R4, R6: element 0 in the high phase, masked
            check("R4", {12'd0, o_pad_out}, {12'd0, cur_d[0][3:0] ^ MASK_O});
            if (cur_oe) begin
                check("R4", {8'd0, b_pad_out}, {8'd0, cur_d[0] ^ MASK_B});
                p0 = cur_d[0] ^ MASK_B;
            end else begin
                p0 = 8'(i * 53 + 7);
                ext_val = p0;
            end
            a0  = 4'(i * 3 + 1);
            xin = a0;

            drv_data = {word1(i + 1), word0(i + 1)};
            drv_oe   = en_of(i + 1);

            #10;
            // R5, R6: element 1 in the low phase, masked
            check("R5", {12'd0, o_pad_out}, {12'd0, cur_d[1][3:0] ^ MASK_O});
            if (cur_oe) begin
                check("R5", {8'd0, b_pad_out}, {8'd0, cur_d[1] ^ MASK_B});
                p1 = cur_d[1] ^ MASK_B;
            end else begin
                p1 = 8'(i * 71 + 200);
                ext_val = p1;
            end
            a1  = 4'(i * 5 + 12);
            xin = a1;

            // R7, R8, R9: pair from the previous cycle, mask removed
            if (i >= 1) begin
                want = exp_b.pop_front();
                check("R8/R9 loopback or external", b_in_data, want);
                want_i = exp_i.pop_front();
                check("R7", {8'd0, i_in_data}, {8'd0, want_i});
            end
            exp_b.push_back({p1 ^ MASK_B, p0 ^ MASK_B});
            exp_i.push_back({a1 ^ MASK_I, a0 ^ MASK_I});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * (NCYC + 40));
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished at %0t", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule